// File: doc/BRIEF.md
# Two-Wire Slave Front End with Pointer Register

This block is the serial front end of a two-channel converter control chip. It oversamples the bus clock and data lines with the system clock and recognises start, repeated start and stop conditions. It answers one 7-bit slave address. The six upper address bits are a parameter, and the lowest bit follows an external select pin, so two of these chips can share one bus.

In a write, the master sends a pointer byte after the address byte and then two data bytes. The block stores the pointer and hands the 16-bit word to the register bank as a one-cycle write strobe. In a read, the master writes the address and pointer, sends a repeated start, and then sends the address again with the direction bit set. The block then shifts out a 16-bit readback word that the register bank selects from the stored pointer. The block only drives an open-drain enable, and only to pull SDA low.

Top module: `i2c_ptr_slave`

## Requirements
- R1: An address byte whose upper seven bits equal {ADDR_HI, addr_sel} is acknowledged: sda_oe is 1 while SCL is high in the ninth clock. Bit 0 of the address byte is the direction bit, with 0 for write and 1 for read.
- R2: An address byte that does not match is not acknowledged. sda_oe then stays 0 until the next start or stop, every following byte is ignored, and no write strobe is issued.
- R3: After a matching write address, the next byte is acknowledged and becomes the stored pointer on ptr_o.
- R4: The two bytes after the pointer are each acknowledged. After the eighth bit of the second byte, wr_stb pulses for exactly one cycle with wr_data = {first byte, second byte}, and ptr_o holds the pointer.
- R5: After a matching read address, the block returns rd_data[15:8] first and then rd_data[7:0], each byte most significant bit first. A 0 bit is sent by setting sda_oe to 1.
- R6: When the master does not acknowledge a read byte (SDA high in the ninth clock), the block releases SDA and drives nothing until the next start or stop.
- R7: When the master acknowledges a read byte, the block continues with the other half of the word, alternating high byte and low byte.
- R8: A start or stop that arrives after at least one bit and before the eighth bit of a byte aborts the transfer. No write strobe is issued, and a following transaction works normally.
- R9: Bytes received after the second data byte are not acknowledged and issue no further strobe.
- R10: After reset, sda_oe = 0, wr_stb = 0 and ptr_o = 0.
- R11: After a stop condition, sda_oe is 0.
- R12: The stored pointer survives repeated starts and stops. A read that sends no pointer returns the word for the pointer written last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Lowest bit of the slave address |
| sda_oe | output | 1 | 1 pulls SDA low |
| ptr_o | output | 8 | Stored pointer, also selects the readback word |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | 16 | Word that goes with wr_stb |
| rd_data | input | 16 | Readback word for ptr_o, from the register bank |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and the upper address bits 010001. It toggles addr_sel between transactions, so both slave addresses are answered, and it sends addresses that differ in the fixed bits and in the select bit. Each bus bit lasts many system clocks, so the synchroniser delay never masks a condition. Aborts are placed in the middle of a data byte, by a stop and by a repeated start.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_MNEXT, S_IGNORE
  } phase_t;

  typedef enum logic [2:0] {
    B_ADDR, B_PTR, B_DHI, B_DLO, B_XTRA
  } slot_t;

  function automatic logic addr_match(input logic [6:0] rx,
                                      input logic [5:0] hi,
                                      input logic pin);
    return rx == {hi, pin};
  endfunction

  function automatic logic [BYTE_W-1:0] byte_of(input logic [WORD_W-1:0] w,
                                                input logic upper);
    return upper ? w[WORD_W-1 -: BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic slot_t next_slot(input slot_t s);
    case (s)
      B_ADDR:  return B_PTR;
      B_PTR:   return B_DHI;
      B_DHI:   return B_DLO;
      default: return B_XTRA;
    endcase
  endfunction
endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic prev,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/i2cp_cond.sv
module i2cp_cond (
  input  logic scl_q,
  input  logic scl_prev,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_evt,
  output logic stop_evt
);
  // conditions count only while SCL has been high for two samples
  assign start_evt = sda_fall & scl_q & scl_prev;
  assign stop_evt  = sda_rise & scl_q & scl_prev;
endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine
  import i2cp_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b010001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_sel,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr_q,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_data,
  output logic              ptr_load,
  output logic              byte_done,
  output logic              abort_evt,
  output logic              ignoring
);
  phase_t            phase;
  slot_t             slot;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] data_hi;
  logic              is_read, ack_q, tx_hi;
  logic [BYTE_W-1:0] rx_byte, tx_next;

  assign rx_byte   = {sh[BYTE_W-2:0], sda_q};
  assign tx_next   = byte_of(rd_word, (phase == S_ACK) ? 1'b1 : tx_hi);
  assign byte_done = (phase == S_RX) && scl_rise && (cnt == CNT_W'(BYTE_W-1));
  assign ptr_load  = byte_done && (slot == B_PTR);
  assign abort_evt = (start_evt || stop_evt) && (phase == S_RX || phase == S_TX) &&
                     (cnt != '0) && (cnt != CNT_W'(BYTE_W));
  assign ignoring  = (phase == S_IGNORE) || (phase == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      slot    <= B_ADDR;
      cnt     <= '0;
      sh      <= '0;
      data_hi <= '0;
      is_read <= 1'b0;
      ack_q   <= 1'b0;
      tx_hi   <= 1'b0;
      ptr_q   <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        phase  <= S_RX;
        slot   <= B_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        phase  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          S_RX: begin
            if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
              sh  <= rx_byte;
              cnt <= cnt + 1'b1;
              if (byte_done) begin
                case (slot)
                  B_ADDR: begin
                    ack_q   <= addr_match(rx_byte[7:1], ADDR_HI, addr_sel);
                    is_read <= rx_byte[0];
                  end
                  B_PTR: begin
                    ptr_q <= rx_byte;
                    ack_q <= 1'b1;
                  end
                  B_DHI: begin
                    data_hi <= rx_byte;
                    ack_q   <= 1'b1;
                  end
                  B_DLO: begin
                    wr_data <= {data_hi, rx_byte};
                    wr_stb  <= 1'b1;
                    ack_q   <= 1'b1;
                  end
                  default: ack_q <= 1'b0;
                endcase
              end
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              if (ack_q) begin
                phase  <= S_ACK;
                sda_oe <= 1'b1;
              end else begin
                phase <= S_IGNORE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (slot == B_ADDR && is_read) begin
                phase  <= S_TX;
                sh     <= tx_next;
                sda_oe <= ~tx_next[BYTE_W-1];
                tx_hi  <= 1'b0;
              end else begin
                phase  <= S_RX;
                sda_oe <= 1'b0;
                slot   <= next_slot(slot);
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W)) begin
                sda_oe <= 1'b0;
                phase  <= S_MACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) phase <= sda_q ? S_IGNORE : S_MNEXT;
          end
          S_MNEXT: begin
            if (scl_fall) begin
              sh     <= tx_next;
              sda_oe <= ~tx_next[BYTE_W-1];
              tx_hi  <= ~tx_hi;
              cnt    <= '0;
              phase  <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2cp_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b010001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] rd_data
);
  logic scl_q, scl_prev, scl_rise, scl_fall;
  logic sda_q, sda_prev, sda_rise, sda_fall;
  logic start_evt, stop_evt;
  logic ptr_load, byte_done, abort_evt, ignoring;

  i2cp_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_i),
    .q(scl_q), .prev(scl_prev), .rise(scl_rise), .fall(scl_fall)
  );

  i2cp_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_i),
    .q(sda_q), .prev(sda_prev), .rise(sda_rise), .fall(sda_fall)
  );

  i2cp_cond u_cond (
    .scl_q(scl_q), .scl_prev(scl_prev), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cp_engine #(.ADDR_HI(ADDR_HI)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_q(sda_q), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_sel(addr_sel), .rd_word(rd_data), .sda_oe(sda_oe), .ptr_q(ptr_o),
    .wr_stb(wr_stb), .wr_data(wr_data), .ptr_load(ptr_load),
    .byte_done(byte_done), .abort_evt(abort_evt), .ignoring(ignoring)
  );
endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_q,
  input logic       scl_rise,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic       byte_done,
  input logic       ptr_load,
  input logic [7:0] ptr_o,
  input logic       abort_evt,
  input logic       ignoring
);
  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_stb_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(byte_done && scl_rise));

  p_quiet_when_ignoring_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  p_release_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  p_drive_only_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  p_drop_only_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_q || $past(start_evt || stop_evt)));

  p_ptr_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_load |=> $stable(ptr_o));

  p_abort_no_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !wr_stb);
endmodule

bind i2c_ptr_slave i2cp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .scl_rise(scl_rise),
  .start_evt(start_evt), .stop_evt(stop_evt), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .byte_done(byte_done), .ptr_load(ptr_load),
  .ptr_o(ptr_o), .abort_evt(abort_evt), .ignoring(ignoring)
);

// File: tb/i2c_ptr_slave_bench.sv
module i2c_ptr_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, wr_stb;
  logic [7:0]  ptr_o;
  logic [15:0] wr_data, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  int errors = 0, checks = 0, stb_cnt = 0;
  logic [7:0]  cap_ptr;
  logic [15:0] cap_data;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] rb_fn(input logic [7:0] p);
    return {p ^ 8'h5A, ~p};
  endfunction

  assign rd_data = rb_fn(ptr_o);

  i2c_ptr_slave u_i2c_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .ptr_o(ptr_o), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  always @(negedge clk) if (wr_stb) begin
    stb_cnt++;
    cap_ptr  = ptr_o;
    cap_data = wr_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] abyte(input logic [5:0] hi, input logic pin,
                                      input logic rw);
    return {hi, pin, rw};
  endfunction

  task automatic q();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) bit_out(b[7-i]);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q(); scl_m = 1'b1; q(); b = {b[6:0], sda_line}; q(); scl_m = 1'b0;
    end
    q(); sda_m = ~mack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic pin, input logic [7:0] p, input logic [15:0] d,
                          output logic [3:0] acks);
    logic a;
    addr_sel = pin;
    bus_start();
    send_byte(abyte(6'b010001, pin, 1'b0), a); acks[3] = a;
    send_byte(p, a);        acks[2] = a;
    send_byte(d[15:8], a);  acks[1] = a;
    send_byte(d[7:0], a);   acks[0] = a;
  endtask

  task automatic do_read(input logic pin, input int nbytes, output logic ack,
                         output logic [31:0] got);
    logic [7:0] b;
    got = '0;
    bus_start();
    send_byte(abyte(6'b010001, pin, 1'b1), ack);
    for (int i = 0; i < nbytes; i++) begin
      recv_byte(i != nbytes - 1, b);
      got = {got[23:0], b};
    end
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [3:0] acks;
    logic a;
    logic [31:0] got;
    logic [7:0] b;
    int exp_stb;
    void'($urandom(32'h00C0FFEE));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sda_oe == 0, "R10 sda_oe", sda_oe, 0);
    chk(wr_stb == 0, "R10 wr_stb", wr_stb, 0);
    chk(ptr_o == 0, "R10 ptr_o", ptr_o, 0);

    // R1 R3 R4 directed write, pin 0
    do_write(1'b0, 8'h3C, 16'hBEEF, acks);
    chk(acks == 4'hF, "R1 R3 R4 acks", acks, 4'hF);
    chk(ptr_o == 8'h3C, "R3 pointer", ptr_o, 8'h3C);
    chk(stb_cnt == 1, "R4 strobe count", stb_cnt, 1);
    chk(cap_data == 16'hBEEF && cap_ptr == 8'h3C, "R4 data", {cap_ptr, cap_data}, 24'h3CBEEF);
    // R9 extra byte not acknowledged
    send_byte(8'h55, a);
    chk(a == 0, "R9 extra nack", a, 0);
    bus_stop();
    chk(sda_oe == 0, "R11 released after stop", sda_oe, 0);
    chk(stb_cnt == 1, "R9 no extra strobe", stb_cnt, 1);

    // R12 pointer kept across stop: read with no pointer byte
    do_read(1'b0, 2, a, got);
    bus_stop();
    chk(a == 1, "R5 read address ack", a, 1);
    chk(got[15:0] == rb_fn(8'h3C), "R12 R5 readback", got[15:0], rb_fn(8'h3C));

    // R7 continuous read alternates bytes, R6 release after nack
    addr_sel = 1'b1;
    bus_start();
    send_byte(abyte(6'b010001, 1'b1, 1'b0), a);
    send_byte(8'h81, a);
    do_read(1'b1, 4, a, got);
    chk(got == {rb_fn(8'h81), rb_fn(8'h81)}, "R7 alternating read", got, {rb_fn(8'h81), rb_fn(8'h81)});
    chk(sda_oe == 0, "R6 released after nack", sda_oe, 0);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R6 no drive after nack", b, 8'hFF);
    bus_stop();

    // R2 mismatch: wrong pin bit, then wrong fixed bits
    addr_sel = 1'b0;
    bus_start();
    send_byte(abyte(6'b010001, 1'b1, 1'b0), a);
    chk(a == 0, "R2 pin mismatch nack", a, 0);
    send_byte(8'h11, a);
    chk(a == 0, "R2 later byte ignored", a, 0);
    send_byte(8'h00, a); send_byte(8'h00, a);
    bus_stop();
    bus_start();
    send_byte(abyte(6'b110001, 1'b0, 1'b0), a);
    chk(a == 0, "R2 fixed bits mismatch nack", a, 0);
    bus_stop();
    chk(stb_cnt == 1 && ptr_o == 8'h81, "R2 no effect", {stb_cnt[7:0], ptr_o}, 16'h0181);

    // R8 abort by stop mid data byte
    bus_start();
    send_byte(abyte(6'b010001, 1'b0, 1'b0), a);
    send_byte(8'h22, a);
    send_byte(8'h12, a);
    send_bits(8'h34, 4);
    bus_stop();
    chk(stb_cnt == 1, "R8 stop abort no strobe", stb_cnt, 1);
    // R8 abort by repeated start mid data byte, then a good write
    bus_start();
    send_byte(abyte(6'b010001, 1'b0, 1'b0), a);
    send_byte(8'h23, a);
    send_byte(8'h56, a);
    send_bits(8'h78, 5);
    bus_start();
    chk(stb_cnt == 1, "R8 start abort no strobe", stb_cnt, 1);
    send_byte(abyte(6'b010001, 1'b0, 1'b0), a);
    send_byte(8'h24, a);
    send_byte(8'h9A, a);
    send_byte(8'hBC, a);
    bus_stop();
    chk(stb_cnt == 2 && cap_data == 16'h9ABC, "R8 recovery write", cap_data, 16'h9ABC);

    // random write then repeated-start read
    exp_stb = 2;
    for (int i = 0; i < 20; i++) begin
      logic pin;
      logic [7:0] p;
      logic [15:0] d;
      pin = 1'($urandom);
      p = 8'($urandom);
      d = 16'($urandom);
      do_write(pin, p, d, acks);
      exp_stb++;
      chk(acks == 4'hF, "R1 R4 random acks", acks, 4'hF);
      chk(stb_cnt == exp_stb && cap_data == d && cap_ptr == p, "R4 random strobe",
          {cap_ptr, cap_data}, {p, d});
      bus_start();
      send_byte(abyte(6'b010001, pin, 1'b0), a);
      send_byte(p, a);
      do_read(pin, 2, a, got);
      bus_stop();
      chk(got[15:0] == rb_fn(p), "R5 R12 random readback", got[15:0], rb_fn(p));
    end
    finish_run();
  end
endmodule